// File: doc/BRIEF.md
# Multi-Channel Down-Counting Tick Timer

This block is a bank of independent 32-bit down-counters behind an APB slave port, meant to serve a system as its periodic tick source and as a free-running clocksource. Every channel owns a small register window holding a reload value, the live count, a control word and a read-to-acknowledge location. A handful of shared registers gather the raw rollover flags, the masked interrupt flags, an acknowledge-all location and a version constant.

Counting is gated by a tick-enable input sampled in the bus clock domain, so a slower timer rate is produced outside the block by pulsing that input. Each channel runs either periodically, reloading its programmed value after it passes zero, or free-running, wrapping to all ones. A rollover always marks the channel's raw flag. The per-channel interrupt line is that flag with the channel's mask applied, and a single OR of all lines is also provided.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset every count, reload value, control word and raw flag is zero, all interrupt lines are low, and the version register at 0xAC reads the parameter default 0x0102_0A00.
- R2: A control write that sets the enable bit (bit 0) of a disabled channel copies its reload value into the counter; after that, each clock cycle with the channel enabled and tick_en high lowers the count by one.
- R3: In periodic mode (control bit 1 set), a tick that finds the count at zero reloads the programmed reload value, so a reload value N gives a period of N+1 ticks.
- R4: In free-running mode (control bit 1 clear), a tick that finds the count at zero sets the count to 0xFFFF_FFFF.
- R5: Every rollover sets the channel's bit in the raw status register at 0xA8 (bit i for channel i), whether or not the channel is masked.
- R6: Channel i's interrupt line irq_ch[i] equals its raw flag gated by the mask bit (control bit 2, 1 = masked); irq_any is the OR of all lines; the per-channel masked status at window offset 0x10 (bit 0) and the combined masked status at 0xA0 (bit i) read the same values.
- R7: A read of a channel's acknowledge offset 0x0C returns its raw flag in bit 0 and clears that flag; a read of 0xA4 returns the OR of all raw flags in bit 0 and clears every flag.
- R8: When an acknowledge and a rollover of the same channel fall in the same cycle, the raw flag stays set.
- R9: A disabled channel holds its count through ticks and never sets its raw flag.
- R10: Writes to a channel's reload value (offset 0x00) are ignored while the channel is enabled; the reload value reads back at offset 0x00.
- R11: Channel i's window starts at byte address 0x14*i, with the reload value at +0x00, the live count at +0x04, the control word at +0x08 (bits 2:0 read back) and the acknowledge at +0x0C.
- R12: The port never stretches a transfer (pready high) or reports an error (pslverr low), and reads of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and counter clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Transfer ready, held high |
| pslverr | output | 1 | Transfer error, held low |
| tick_en | input | 1 | Count-enable pulse for all channels |
| irq_ch | output | 8 | Per-channel masked interrupt lines |
| irq_any | output | 1 | OR of all per-channel lines |

## Verification
The bench aims at the zero crossing in both modes: a design that reloads all ones in periodic mode, or the programmed value in free-running mode, shows the wrong count one tick after zero. It masks a channel and checks that the raw flag still rises while the line stays low, which catches a design that gates the raw flag with the mask. It lands an acknowledge read on the very cycle a rollover occurs, where a design giving the clear priority would lose an interrupt, and it rewrites the reload value while enabled to catch a design that lets the new value leak into the next period. Decode is probed at the last channel's window and an unmapped address so that a wrong stride aliases writes into a neighbour.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Control word, bits 2:0 of the control register
    typedef struct packed {
        logic mask;      // bit 2: 1 = interrupt line suppressed
        logic periodic;  // bit 1: 1 = reload programmed value, 0 = wrap to all ones
        logic en;        // bit 0: counter runs on tick
    } tmr_ctrl_t;

    localparam int CTRL_W = $bits(tmr_ctrl_t);

    // Offsets inside one channel window
    localparam int OFF_LOAD  = 'h00;
    localparam int OFF_COUNT = 'h04;
    localparam int OFF_CTRL  = 'h08;
    localparam int OFF_ACK   = 'h0C;
    localparam int OFF_MSTAT = 'h10;

    // Offsets of the shared registers above the last window
    localparam int G_MSTAT = 'h00;
    localparam int G_CLR   = 'h04;
    localparam int G_RAW   = 'h08;
    localparam int G_VER   = 'h0C;

endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_we,
    input  logic             ctrl_we,
    input  logic [CNT_W-1:0] wdata,
    input  logic             clr,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] load,
    output tmr_ctrl_t        ctrl,
    output logic             raw,
    output logic             irq
);

    typedef struct packed {
        logic [CNT_W-1:0] load;
        logic [CNT_W-1:0] count;
        tmr_ctrl_t        ctrl;
        logic             raw;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     en_rise_d;
    logic     roll_d;

    always_comb begin
        st_d      = st_q;
        roll_d    = 1'b0;
        en_rise_d = ctrl_we && wdata[0] && !st_q.ctrl.en;

        if (load_we && !st_q.ctrl.en) begin
            st_d.load = wdata;
        end
        if (ctrl_we) begin
            st_d.ctrl = tmr_ctrl_t'(wdata[CTRL_W-1:0]);
        end

        if (en_rise_d) begin
            st_d.count = st_q.load;
        end else if (st_q.ctrl.en && tick) begin
            if (st_q.count == '0) begin
                roll_d     = 1'b1;
                st_d.count = st_q.ctrl.periodic ? st_q.load : '1;
            end else begin
                st_d.count = st_q.count - 1'b1;
            end
        end

        // a rollover in the clearing cycle keeps the flag
        st_d.raw = (st_q.raw && !clr) || roll_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.count;
    assign load  = st_q.load;
    assign ctrl  = st_q.ctrl;
    assign raw   = st_q.raw;
    assign irq   = st_q.raw && !st_q.ctrl.mask;

    // R2: enabled tick away from zero steps down by one
    assert_step_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.en && tick && st_q.count != '0 && !ctrl_we)
        |=> (count == $past(count) - 1'b1));

    // R4: free-running wrap to all ones
    assert_wrap_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.en && !st_q.ctrl.periodic && tick && st_q.count == '0 && !ctrl_we)
        |=> (count == '1));

    // R5: rollover raises the raw flag regardless of mask
    assert_roll_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.en && tick && st_q.count == '0 && !ctrl_we) |=> raw);

    // R8: clear coinciding with rollover leaves the flag set
    assert_clear_loses_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && st_q.ctrl.en && tick && st_q.count == '0 && !ctrl_we) |=> raw);

    // R9: a disabled channel holds its count and sets no flag
    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctrl.en && !(ctrl_we && wdata[0]))
        |=> ($stable(count) && !$rose(raw)));

    // R10: reload writes are dropped while running
    assert_load_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.en && load_we) |=> $stable(load));

endmodule

// File: rtl/tmr_apb_regs.sv
module tmr_apb_regs
    import tmr_pkg::*;
#(
    parameter int          NUM_CH  = 8,
    parameter int          CNT_W   = 32,
    parameter int          ADDR_W  = 8,
    parameter int          STRIDE  = 'h14,
    parameter logic [31:0] VERSION = 32'h0102_0A00
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          psel,
    input  logic                          penable,
    input  logic                          pwrite,
    input  logic [ADDR_W-1:0]             paddr,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  ch_count,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  ch_load,
    input  logic [NUM_CH-1:0][CTRL_W-1:0] ch_ctrl,
    input  logic [NUM_CH-1:0]             ch_raw,
    input  logic [NUM_CH-1:0]             ch_irq,
    output logic [NUM_CH-1:0]             load_we,
    output logic [NUM_CH-1:0]             ctrl_we,
    output logic [NUM_CH-1:0]             clr,
    output logic [CNT_W-1:0]              prdata
);

    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int G_BASE = NUM_CH * STRIDE;

    localparam logic [ADDR_W-1:0] A_MSTAT = ADDR_W'(G_BASE + G_MSTAT);
    localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(G_BASE + G_CLR);
    localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'(G_BASE + G_RAW);
    localparam logic [ADDR_W-1:0] A_VER   = ADDR_W'(G_BASE + G_VER);

    logic              ch_hit_d;
    logic [CH_W-1:0]   ch_sel_d;
    logic [ADDR_W-1:0] ch_off_d;
    logic              g_hit_d;
    logic              wr_d;
    logic              rd_d;

    // Window decode: one comparison pair per channel
    always_comb begin
        ch_hit_d = 1'b0;
        ch_sel_d = '0;
        ch_off_d = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (paddr >= ADDR_W'(i * STRIDE) && paddr < ADDR_W'((i + 1) * STRIDE)) begin
                ch_hit_d = 1'b1;
                ch_sel_d = CH_W'(i);
                ch_off_d = paddr - ADDR_W'(i * STRIDE);
            end
        end
        g_hit_d = (paddr == A_MSTAT) || (paddr == A_CLR) ||
                  (paddr == A_RAW)   || (paddr == A_VER);
        wr_d = psel && penable && pwrite;
        rd_d = psel && penable && !pwrite;
    end

    // Strobes to the channels
    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            load_we[i] = wr_d && ch_hit_d && ch_sel_d == CH_W'(i) && ch_off_d == ADDR_W'(OFF_LOAD);
            ctrl_we[i] = wr_d && ch_hit_d && ch_sel_d == CH_W'(i) && ch_off_d == ADDR_W'(OFF_CTRL);
            clr[i]     = (rd_d && ch_hit_d && ch_sel_d == CH_W'(i) && ch_off_d == ADDR_W'(OFF_ACK)) ||
                         (rd_d && paddr == A_CLR);
        end
    end

    // Read mux
    always_comb begin
        prdata = '0;
        if (ch_hit_d) begin
            case (ch_off_d)
                ADDR_W'(OFF_LOAD):  prdata = ch_load[ch_sel_d];
                ADDR_W'(OFF_COUNT): prdata = ch_count[ch_sel_d];
                ADDR_W'(OFF_CTRL):  prdata[CTRL_W-1:0] = ch_ctrl[ch_sel_d];
                ADDR_W'(OFF_ACK):   prdata[0] = ch_raw[ch_sel_d];
                ADDR_W'(OFF_MSTAT): prdata[0] = ch_irq[ch_sel_d];
                default:            prdata = '0;
            endcase
        end else if (g_hit_d) begin
            case (paddr)
                A_MSTAT: prdata[NUM_CH-1:0] = ch_irq;
                A_CLR:   prdata[0] = |ch_raw;
                A_RAW:   prdata[NUM_CH-1:0] = ch_raw;
                A_VER:   prdata = CNT_W'(VERSION);
                default: prdata = '0;
            endcase
        end
    end

    // R12: nothing decoded means a zero read
    assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !pwrite && !ch_hit_d && !g_hit_d) |-> (prdata == '0));

    // R7: at most one channel acknowledged by a window read
    assert_one_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_d && paddr != A_CLR) |-> $onehot0(clr));

endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
    import tmr_pkg::*;
#(
    parameter int          NUM_CH  = 8,
    parameter int          CNT_W   = 32,
    parameter int          ADDR_W  = 8,
    parameter int          STRIDE  = 'h14,
    parameter logic [31:0] VERSION = 32'h0102_0A00
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [CNT_W-1:0]  pwdata,
    output logic [CNT_W-1:0]  prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              tick_en,
    output logic [NUM_CH-1:0] irq_ch,
    output logic              irq_any
);

    logic [NUM_CH-1:0][CNT_W-1:0]  ch_count;
    logic [NUM_CH-1:0][CNT_W-1:0]  ch_load;
    logic [NUM_CH-1:0][CTRL_W-1:0] ch_ctrl;
    logic [NUM_CH-1:0]             ch_raw;
    logic [NUM_CH-1:0]             ch_irq;
    logic [NUM_CH-1:0]             load_we;
    logic [NUM_CH-1:0]             ctrl_we;
    logic [NUM_CH-1:0]             clr;

    tmr_apb_regs #(
        .NUM_CH (NUM_CH),
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W),
        .STRIDE (STRIDE),
        .VERSION(VERSION)
    ) u_regs (
        .clk     (pclk),
        .rst_n   (presetn),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .ch_count(ch_count),
        .ch_load (ch_load),
        .ch_ctrl (ch_ctrl),
        .ch_raw  (ch_raw),
        .ch_irq  (ch_irq),
        .load_we (load_we),
        .ctrl_we (ctrl_we),
        .clr     (clr),
        .prdata  (prdata)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        tmr_ctrl_t ctrl_w;

        tmr_channel #(
            .CNT_W(CNT_W)
        ) u_chan (
            .clk    (pclk),
            .rst_n  (presetn),
            .tick   (tick_en),
            .load_we(load_we[g]),
            .ctrl_we(ctrl_we[g]),
            .wdata  (pwdata),
            .clr    (clr[g]),
            .count  (ch_count[g]),
            .load   (ch_load[g]),
            .ctrl   (ctrl_w),
            .raw    (ch_raw[g]),
            .irq    (ch_irq[g])
        );

        assign ch_ctrl[g] = ctrl_w;

        // R6: a masked channel never drives its line
        assert_mask_quiet_R6: assert property (@(posedge pclk) disable iff (!presetn)
            ctrl_w.mask |-> !irq_ch[g]);
    end

    assign irq_ch  = ch_irq;
    assign irq_any = |ch_irq;
    assign pready  = 1'b1;
    assign pslverr = 1'b0;

endmodule

// File: tb/tick_timer_bank_test.sv
module tick_timer_bank_test;

    localparam int CLK_PERIOD = 10;

    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic        pslverr;
    logic        tick_en = 1'b0;
    logic [7:0]  irq_ch;
    logic        irq_any;

    tick_timer_bank uut (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .tick_en(tick_en),
        .irq_ch(irq_ch), .irq_any(irq_any)
    );

    always #(CLK_PERIOD / 2) pclk = ~pclk;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t       exp_q[$];
    logic [31:0] act_s;
    event        obs_ev;
    int          n_vec = 0;
    int          n_bad = 0;
    bit          done = 0;

    // Monitor: pops one expected item per observation
    initial forever begin
        @(obs_ev);
        if (exp_q.size() != 0) begin
            item_t it;
            it = exp_q.pop_front();
            n_vec++;
            if (act_s !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual %h expected %h", it.tag, act_s, it.exp);
            end
        end
    end

    task automatic push_check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        exp_q.push_back('{exp, tag});
        act_s = act;
        -> obs_ev;
        #1;
    endtask

    task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge pclk);
        penable = 1'b1;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_rd(input logic [7:0] a, input logic [31:0] exp, input string tag,
                          input logic tk = 1'b0);
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge pclk);
        penable = 1'b1; tick_en = tk;
        #1;
        push_check(prdata, exp, tag);
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; tick_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge pclk);
            tick_en = 1'b1;
        end
        @(negedge pclk);
        tick_en = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge pclk);
        presetn = 1'b1;

        // R1: reset state
        apb_rd(8'h08, 32'h0, "R1 ctrl0");
        apb_rd(8'h04, 32'h0, "R1 count0");
        apb_rd(8'hA8, 32'h0, "R1 raw");
        apb_rd(8'hAC, 32'h0102_0A00, "R1 version");
        push_check({23'b0, irq_any, irq_ch}, 32'h0, "R1 irq lines");

        // R2 / R3: periodic channel 0, reload 5
        apb_wr(8'h00, 32'd5);
        apb_wr(8'h08, 32'h3);
        apb_rd(8'h04, 32'd5, "R2 enable loads");
        apb_rd(8'h08, 32'h3, "R11 ctrl readback");
        ticks(3);
        apb_rd(8'h04, 32'd2, "R2 step down");
        ticks(3);
        apb_rd(8'h04, 32'd5, "R3 periodic reload");
        apb_rd(8'hA8, 32'h1, "R5 raw ch0");
        push_check({23'b0, irq_any, irq_ch}, 32'h101, "R6 irq ch0");
        apb_rd(8'hA0, 32'h1, "R6 combined mstat");
        apb_rd(8'h10, 32'h1, "R6 ch0 mstat");
        apb_rd(8'h0C, 32'h1, "R7 ack returns flag");
        apb_rd(8'hA8, 32'h0, "R7 ack cleared");
        push_check({23'b0, irq_any, irq_ch}, 32'h0, "R7 lines low");
        apb_wr(8'h08, 32'h0);

        // R4: free-running channel 1, reload 2
        apb_wr(8'h14, 32'd2);
        apb_wr(8'h1C, 32'h1);
        ticks(3);
        apb_rd(8'h18, 32'hFFFF_FFFF, "R4 wrap to ones");
        apb_rd(8'h04, 32'd5, "R9 disabled ch0 holds");
        apb_rd(8'hA8, 32'h2, "R9 no flag from idle ch0");
        apb_rd(8'h0C, 32'h0, "R7 ack of clear ch0");
        apb_rd(8'h18, 32'hFFFF_FFFF, "R7 ack side effect free");
        apb_rd(8'h1C, 32'h1, "R11 ch1 ctrl");
        apb_rd(8'h2C, 32'h0, "R11 ch2 count untouched");
        apb_wr(8'h1C, 32'h0);
        apb_rd(8'hA4, 32'h1, "R7 clear-all returns any");

        // R5 / R6: masked free-running channel 2, reload 0
        apb_wr(8'h30, 32'h5);
        ticks(1);
        apb_rd(8'h2C, 32'hFFFF_FFFF, "R4 wrap from zero");
        apb_rd(8'hA8, 32'h4, "R5 raw while masked");
        apb_rd(8'hA0, 32'h0, "R6 combined masked");
        apb_rd(8'h38, 32'h0, "R6 ch2 mstat masked");
        push_check({23'b0, irq_any, irq_ch}, 32'h0, "R6 masked line low");
        apb_rd(8'hA4, 32'h1, "R7 clear-all");
        apb_rd(8'hA8, 32'h0, "R7 all cleared");
        apb_wr(8'h30, 32'h0);

        // R10 / R8: periodic channel 3
        apb_wr(8'h3C, 32'd7);
        apb_wr(8'h44, 32'h3);
        apb_wr(8'h3C, 32'd99);
        apb_rd(8'h3C, 32'd7, "R10 load locked");
        ticks(8);
        apb_rd(8'h40, 32'd7, "R10 reload keeps old value");
        apb_rd(8'hA8, 32'h8, "R5 raw ch3");
        ticks(7);
        apb_rd(8'h40, 32'd0, "R2 at zero");
        apb_rd(8'h48, 32'h1, "R7 ack at rollover", 1'b1);
        apb_rd(8'hA8, 32'h8, "R8 rollover beats clear");
        apb_rd(8'h40, 32'd7, "R3 reload during ack");
        apb_rd(8'h48, 32'h1, "R7 plain ack");
        apb_rd(8'hA8, 32'h0, "R7 ch3 cleared");
        apb_wr(8'h44, 32'h0);

        // R11 / R12: last window and unmapped space
        apb_wr(8'h8C, 32'h0000_1234);
        apb_rd(8'h8C, 32'h0000_1234, "R11 ch7 load");
        apb_rd(8'h78, 32'h0, "R11 ch6 load untouched");
        apb_rd(8'hB0, 32'h0, "R12 unmapped");
        apb_rd(8'h9E, 32'h0, "R12 hole in window");
        push_check({30'b0, pready, pslverr}, 32'h2, "R12 ready no error");

        #(CLK_PERIOD);
        done = 1;
        summary();
        $finish;
    end

endmodule